// File: doc/BRIEF.md
# Conversion Clock Source Selector

This block supplies the conversion clock of a sampling converter and times one conversion. An optional external clock pin is watched from the reference clock domain. While rising edges arrive often enough, each one becomes a one-cycle enable on the selected-clock output. When the edges stop, a free-running internal divider takes over. The internal divider runs only while the external source is absent.

A start request begins a conversion. The conversion lasts a fixed number of selected-clock enables and ends with a one-cycle done pulse. If the clock source switches while the conversion runs, that one result is flagged as suspect. Source switches while idle leave later results clean. While idle, the block also produces a serial clock at one eighth of the selected-clock rate for the converter's self-clocked read mode.

Top module: `convclk_select`

## Requirements
- R1: With no external source present, `conv_tick` pulses for one reference cycle once every `INT_DIV` reference cycles. The internal divider is held off while the external source is present.
- R2: The external pin passes through a two-stage synchronizer. A rising edge on the pin is recognised in the reference domain two clocks after it is first sampled high. A recognised edge marks the external source present from the next cycle. While the source is present, each recognised edge gives exactly one `conv_tick` pulse, one clock later.
- R3: If no edge is recognised for `TIMEOUT_RELOAD` reference cycles, the external source counts as absent and the internal divider takes over. Edges spaced at most `TIMEOUT_RELOAD` cycles apart keep the external source selected.
- R4: A start request while idle raises `conv_busy` on the next cycle. After exactly `CONV_CYCLES` `conv_tick` pulses have been seen while busy, `conv_busy` falls and `conv_done` pulses for one cycle in the same cycle.
- R5: While idle, `sclk` is a divide-by-8 of `conv_tick`: it changes level after every fourth pulse, starting low. It is held low while busy.
- R6: If the selected source changes at any point while busy, `result_suspect` is 1 from the `conv_done` cycle until the next accepted start.
- R7: Source changes while idle do not set `result_suspect` for the next conversion. An accepted start clears `result_suspect`.
- R8: A start request while busy is ignored: the conversion length and `conv_done` timing are unchanged.
- R9: Synchronous active-high reset clears every output to 0 and selects the internal source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference system clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk_pin | input | 1 | Optional external conversion clock, asynchronous |
| start_req | input | 1 | Start-conversion request, sampled while idle |
| conv_tick | output | 1 | Selected conversion-clock enable, one reference cycle wide |
| conv_busy | output | 1 | Conversion in progress |
| conv_done | output | 1 | One-cycle pulse when a conversion ends |
| result_suspect | output | 1 | Last result was taken across a source change |
| sclk | output | 1 | Serial clock, selected clock divided by 8, low while busy |

## Verification
The hardest case to reach is a source change inside a conversion. It needs a conversion long enough to cover both the external timeout and the first recognised edge. The stimulus turns the external pin generator on or off partway through a conversion that is already running, in both directions. It also toggles the source while idle just before a start, so the suspect flag is shown to cover only the conversion that saw the change. A behavioural model of edge recognition, timeout, divider and conversion length is compared with every output on every clock. This covers the edge recognised at the exact timeout boundary and start requests repeated while busy.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } clk_src_e;
endpackage

// File: rtl/ccs_ext_detect.sv
module ccs_ext_detect #(
  parameter int TIMEOUT_RELOAD = 1000,
  localparam int WDW = $clog2(TIMEOUT_RELOAD + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic edge_o,
  output logic present_o
);
  localparam logic [WDW-1:0] WD_FULL = WDW'(TIMEOUT_RELOAD);

  logic           meta_q, sync_q, hist_q;
  logic [WDW-1:0] wd_q;

  // two-stage synchronizer plus one history stage for edge recognition
  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      hist_q <= 1'b0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  assign edge_o = sync_q & ~hist_q;

  // activity watchdog: reloaded on each recognised edge
  always_ff @(posedge clk) begin
    if (rst)                 wd_q <= '0;
    else if (edge_o)         wd_q <= WD_FULL;
    else if (wd_q != '0)     wd_q <= wd_q - 1'b1;
  end

  assign present_o = (wd_q != '0);

  AST_EDGE_MAKES_PRESENT: assert property (@(posedge clk) disable iff (rst)
    edge_o |=> present_o); // R2
  AST_ABSENT_NEEDS_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(present_o) |-> !$past(edge_o)); // R3
endmodule

// File: rtl/ccs_int_osc.sv
module ccs_int_osc #(
  parameter int INT_DIV = 4,
  localparam int ICW = $clog2(INT_DIV)
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic tick_o
);
  localparam logic [ICW-1:0] DIV_LAST = ICW'(INT_DIV - 1);

  logic [ICW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      div_q  <= '0;
      tick_o <= 1'b0;
    end else if (div_q == DIV_LAST) begin
      div_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      div_q  <= div_q + 1'b1;
      tick_o <= 1'b0;
    end
  end

  AST_OSC_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !tick_o); // R1
  AST_OSC_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o); // R1
endmodule

// File: rtl/ccs_src_mux.sv
module ccs_src_mux
  import ccs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ext_present_i,
  input  logic ext_edge_i,
  input  logic int_tick_i,
  output logic tick_o,
  output logic src_chg_o
);
  clk_src_e sel_q;
  clk_src_e sel_now;

  assign sel_now = ext_present_i ? SRC_EXT : SRC_INT;

  // enable changes source only on a reference-clock boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= SRC_INT;
      tick_o <= 1'b0;
    end else begin
      sel_q  <= sel_now;
      tick_o <= (sel_now == SRC_EXT) ? ext_edge_i : int_tick_i;
    end
  end

  assign src_chg_o = (sel_q != sel_now);

  AST_EXT_TICK_FROM_EDGE: assert property (@(posedge clk) disable iff (rst)
    (ext_present_i && ext_edge_i) |=> tick_o); // R2
  AST_INT_TICK_FROM_OSC: assert property (@(posedge clk) disable iff (rst)
    (!ext_present_i && !int_tick_i) |=> !tick_o); // R1
endmodule

// File: rtl/ccs_conv_timer.sv
module ccs_conv_timer #(
  parameter int CONV_CYCLES = 20510,
  parameter int SCLK_DIV    = 8,
  localparam int CCW = $clog2(CONV_CYCLES),
  localparam int SCW = $clog2(SCLK_DIV)
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic tick_i,
  input  logic src_chg_i,
  output logic busy_o,
  output logic done_o,
  output logic suspect_o,
  output logic sclk_o
);
  localparam logic [CCW-1:0] CONV_LAST = CCW'(CONV_CYCLES - 1);

  logic [CCW-1:0] cnt_q;
  logic           taint_q;
  logic [SCW-1:0] sdiv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
      suspect_o <= 1'b0;
      taint_q   <= 1'b0;
      cnt_q     <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          busy_o    <= 1'b1;
          cnt_q     <= '0;
          taint_q   <= 1'b0;
          suspect_o <= 1'b0;
        end
      end else begin
        if (src_chg_i) taint_q <= 1'b1;
        if (tick_i) begin
          if (cnt_q == CONV_LAST) begin
            busy_o    <= 1'b0;
            done_o    <= 1'b1;
            cnt_q     <= '0;
            suspect_o <= taint_q | src_chg_i;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  // serial clock divider, active only while idle
  always_ff @(posedge clk) begin
    if (rst || busy_o) sdiv_q <= '0;
    else if (tick_i)   sdiv_q <= sdiv_q + 1'b1;
  end

  assign sclk_o = sdiv_q[SCW-1];

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o); // R4
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R4
  AST_SCLK_LOW_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> !sclk_o); // R5
  AST_START_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> !suspect_o); // R7
  AST_CHG_TAINTS: assert property (@(posedge clk) disable iff (rst)
    (busy_o && src_chg_i && !done_o) |=> (taint_q || suspect_o)); // R6
endmodule

// File: rtl/convclk_select.sv
module convclk_select #(
  parameter int TIMEOUT_RELOAD = 1000,
  parameter int INT_DIV        = 4,
  parameter int CONV_CYCLES    = 20510,
  parameter int SCLK_DIV       = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_clk_pin,
  input  logic start_req,
  output logic conv_tick,
  output logic conv_busy,
  output logic conv_done,
  output logic result_suspect,
  output logic sclk
);
  logic ext_edge, ext_present, int_tick, src_chg;

  ccs_ext_detect #(.TIMEOUT_RELOAD(TIMEOUT_RELOAD)) u_det (
    .clk(clk), .rst(rst), .pin_i(ext_clk_pin),
    .edge_o(ext_edge), .present_o(ext_present)
  );

  ccs_int_osc #(.INT_DIV(INT_DIV)) u_osc (
    .clk(clk), .rst(rst), .en_i(!ext_present), .tick_o(int_tick)
  );

  ccs_src_mux u_mux (
    .clk(clk), .rst(rst), .ext_present_i(ext_present),
    .ext_edge_i(ext_edge), .int_tick_i(int_tick),
    .tick_o(conv_tick), .src_chg_o(src_chg)
  );

  ccs_conv_timer #(.CONV_CYCLES(CONV_CYCLES), .SCLK_DIV(SCLK_DIV)) u_tmr (
    .clk(clk), .rst(rst), .start_i(start_req), .tick_i(conv_tick),
    .src_chg_i(src_chg), .busy_o(conv_busy), .done_o(conv_done),
    .suspect_o(result_suspect), .sclk_o(sclk)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!conv_busy && !conv_done && !conv_tick)); // R9
endmodule

// File: tb/sim_convclk_select.sv
`timescale 1ns/1ps
module sim_convclk_select;
  localparam int RELOAD = 16;
  localparam int DIV    = 3;
  localparam int CONV   = 30;

  logic clk = 1'b0;
  logic rst, pin, start;
  logic conv_tick, conv_busy, conv_done, result_suspect, sclk;

  int checks = 0;
  int errors = 0;
  int dones_seen = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  convclk_select #(.TIMEOUT_RELOAD(RELOAD), .INT_DIV(DIV),
                   .CONV_CYCLES(CONV), .SCLK_DIV(8)) u0 (
    .clk(clk), .rst(rst), .ext_clk_pin(pin), .start_req(start),
    .conv_tick(conv_tick), .conv_busy(conv_busy), .conv_done(conv_done),
    .result_suspect(result_suspect), .sclk(sclk)
  );

  // behavioural reference: pin sample history, quiet timer, divider, counters
  int hist[$];
  int quiet, ph, m_itick, m_tick, m_src, m_busy, m_left, m_done, m_taint, m_susp, m_sdiv;

  initial begin
    hist = '{0, 0, 0};
    quiet = 0; ph = 0; m_itick = 0; m_tick = 0; m_src = 0; m_busy = 0;
    m_left = 0; m_done = 0; m_taint = 0; m_susp = 0; m_sdiv = 0;
  end

  always @(posedge clk) begin
    int seen, here, chg, nt;
    seen = (hist[1] == 1 && hist[2] == 0);
    here = (quiet > 0);
    chg  = (m_src != here);
    if (rst) begin
      hist = '{0, 0, 0};
      quiet = 0; ph = 0; m_itick = 0; m_tick = 0; m_src = 0; m_busy = 0;
      m_left = 0; m_done = 0; m_taint = 0; m_susp = 0; m_sdiv = 0;
    end else begin
      m_sdiv = m_busy ? 0 : (m_tick ? (m_sdiv + 1) % 8 : m_sdiv);
      m_done = 0;
      if (!m_busy) begin
        if (start) begin m_busy = 1; m_left = CONV; m_taint = 0; m_susp = 0; end
      end else begin
        if (chg) m_taint = 1;
        if (m_tick) begin
          m_left--;
          if (m_left == 0) begin m_busy = 0; m_done = 1; m_susp = m_taint; end
        end
      end
      nt = here ? seen : m_itick;
      if (here) begin ph = 0; m_itick = 0; end
      else begin ph++; m_itick = (ph == DIV); if (ph == DIV) ph = 0; end
      m_tick = nt;
      m_src = here;
      quiet = seen ? RELOAD : (quiet > 0 ? quiet - 1 : 0);
      void'(hist.pop_back());
      hist.push_front(int'(pin));
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R1/R2/R3 conv_tick", conv_tick, m_tick);
      chk("R4/R8 conv_busy", conv_busy, m_busy);
      chk("R4 conv_done", conv_done, m_done);
      chk("R5 sclk", sclk, (m_sdiv >= 4));
      chk("R6/R7 result_suspect", result_suspect, m_susp);
      if (conv_done) dones_seen++;
    end
  end

  // external pin generator
  bit ext_on = 0;
  int half = 4;
  always begin
    @(negedge clk);
    if (ext_on) begin
      repeat (half - 1) @(negedge clk);
      pin = ~pin;
    end
  end

  task automatic wait_done(int limit, output int got);
    got = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (conv_done) begin got = 1; break; end
    end
  endtask

  task automatic pulse_start;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  initial begin
    int got;
    rst = 1; pin = 0; start = 0;
    repeat (4) @(negedge clk);
    // R9 reset state
    chk("R9 busy", conv_busy, 0);
    chk("R9 done", conv_done, 0);
    chk("R9 tick", conv_tick, 0);
    chk("R9 sclk", sclk, 0);
    chk("R9 suspect", result_suspect, 0);
    rst = 0;
    repeat (40) @(negedge clk);

    // R1 R4: fully internal conversion, with repeated starts while busy (R8)
    pulse_start;
    repeat (10) @(negedge clk);
    start = 1; repeat (5) @(negedge clk); start = 0;
    wait_done(400, got);
    chk("R4 internal done reached", got, 1);
    @(negedge clk);
    chk("R6 internal result clean", result_suspect, 0);

    // R7: source switch while idle
    half = 4; ext_on = 1;
    repeat (60) @(negedge clk);
    pulse_start;
    wait_done(600, got);
    chk("R2 external done reached", got, 1);
    @(negedge clk);
    chk("R7 idle switch leaves result clean", result_suspect, 0);

    // R3 boundary: edges exactly RELOAD apart keep external
    half = RELOAD / 2;
    repeat (120) @(negedge clk);
    half = 4;
    repeat (40) @(negedge clk);

    // R6: external to internal during conversion
    pulse_start;
    repeat (50) @(negedge clk);
    ext_on = 0;
    wait_done(800, got);
    chk("R6 done after fallback", got, 1);
    @(negedge clk);
    chk("R6 suspect after ext loss", result_suspect, 1);
    repeat (20) @(negedge clk);
    chk("R6 suspect held while idle", result_suspect, 1);

    // R6: internal to external during conversion
    pulse_start;
    @(negedge clk);
    chk("R7 start clears suspect", result_suspect, 0);
    repeat (20) @(negedge clk);
    ext_on = 1;
    wait_done(800, got);
    chk("R6 done after switch-in", got, 1);
    @(negedge clk);
    chk("R6 suspect after ext arrival", result_suspect, 1);

    // R5: idle divider runs for a while
    repeat (200) @(negedge clk);
    ext_on = 0;
    repeat (100) @(negedge clk);
    chk("R4 total conversions", dones_seen, 4);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule